// File: doc/BRIEF.md
# Run-Length Byte Packer with Channel-Group Masking

This block turns a stream of captured samples into a byte stream for a slow host link. Each sample is split into 8-bit channel groups. Any group marked off in `grp_off` is dropped, and the bytes of the remaining groups are sent lowest group first. Only the enabled groups are sent, so the link carries no bytes for channels the host did not ask for.

With `rle_en` set, the block compresses consecutive identical samples. It sends the sample once. If the sample repeated, it then sends a count word: a word of the same enabled width whose most significant bit is 1 and whose other bits give the number of extra repeats. Because that top bit marks a count, the top bit of every data word is forced to 0. Samples are therefore compared after that masking. A run ends in one of three ways: a different sample arrives, the count reaches the largest value the enabled width can hold, or the input marks its final sample with `s_last`.

Both sides use a valid/ready handshake. The configuration inputs are expected to stay unchanged while a stream is in flight. The packer sends samples in the order it receives them. The memory reader feeding it delivers the newest sample first.

Top module: `rle_byte_packer`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: Setting `grp_off[g]` to 1 removes byte g (sample bits 8g+7..8g) from the output. The packed word is the enabled bytes placed side by side with no gaps.
- R3: The enabled bytes of a word go out in ascending group order, lowest group first.
- R4: With `rle_en` 0, every accepted sample produces exactly one byte per enabled group, with all data bits unchanged, including bit 7 of the last byte. `m_valid` rises in the cycle after the sample is accepted.
- R5: With `rle_en` 1, bit 7 of the last byte of every data word is sent as 0. Two samples that differ only in that bit count as equal.
- R6: With `rle_en` 1, a run of L equal consecutive samples sends the data word once. When L > 1, a count word follows: bit 7 of its last byte is 1 and its remaining bits hold L-1. A run of length 1 sends no count word.
- R7: The count saturates at 2^(8n-1)-1, where n is the number of enabled groups. The next equal sample after saturation flushes the run and starts a new one.
- R8: An accepted sample with `s_last` = 1 causes the pending run, including that sample, to be sent without waiting for more input.
- R9: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` stays stable. No byte is lost or repeated.
- R10: With every group disabled, samples are still accepted but no byte is ever sent.
- R11: `s_ready` is 0 whenever `m_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_off | input | GROUPS | One bit per channel group; 1 drops that group |
| rle_en | input | 1 | Enables run-length compression |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | GROUPS*GW | Captured sample |
| s_last | input | 1 | Marks the final sample of a stream |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Consumer takes the byte |
| m_data | output | GW | Output byte |

## Verification
The bench targets these corner cases:
- Saturation: 129 equal samples with one group enabled. A design that wraps the count would send 0x80 instead of 0xFF. A design that ignores the limit would send a single run.
- Equality after masking: two samples that differ only in the top bit. A design that compares before forcing the bit to 0 would split them into two data words.
- Sparse masks: group patterns with a hole in them. A design that keeps byte positions fixed instead of packing would send the wrong bytes, and would place the count flag in the wrong byte.
- End of stream and back-pressure: streams ending on a run or on a single sample, with random stalls on the output. A design that waits for a following sample would hang at `s_last`. A design that shifts on a stalled cycle would drop bytes.

// File: rtl/rle_byte_packer.sv
module rle_byte_packer #(
  parameter int GROUPS = 4,
  parameter int GW     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GROUPS-1:0]      grp_off,
  input  logic                   rle_en,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [GROUPS*GW-1:0]   s_data,
  input  logic                   s_last,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [GW-1:0]          m_data
);
  localparam int DW = GROUPS * GW;
  localparam int CW = $clog2(GROUPS + 1);

  logic [CW-1:0] n_en;
  logic [DW-1:0] packed_w, top_bit, data_w, max_cnt, cnt_word;

  logic [DW-1:0] run_val, run_cnt, tx_word, tx2_word;
  logic [CW-1:0] tx_idx;
  logic          have_run, flush_pend, tx_busy, tx2_pend;
  logic          accept, fire, same;

  always_comb begin
    n_en     = '0;
    packed_w = '0;
    top_bit  = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (!grp_off[g]) begin
        packed_w[n_en*GW +: GW] = s_data[g*GW +: GW];
        n_en = n_en + CW'(1);
      end
    end
    if (n_en != '0) top_bit[n_en*GW-1] = 1'b1;
  end

  assign data_w   = rle_en ? (packed_w & ~top_bit) : packed_w;
  assign max_cnt  = top_bit - DW'(1);
  assign cnt_word = top_bit | run_cnt;

  assign s_ready = !tx_busy && !flush_pend;
  assign m_valid = tx_busy;
  assign m_data  = tx_word[GW-1:0];
  assign accept  = s_valid && s_ready;
  assign fire    = m_valid && m_ready;
  assign same    = have_run && (data_w == run_val) && (run_cnt != max_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_val    <= '0;
      run_cnt    <= '0;
      have_run   <= 1'b0;
      flush_pend <= 1'b0;
      tx_busy    <= 1'b0;
      tx_word    <= '0;
      tx2_word   <= '0;
      tx2_pend   <= 1'b0;
      tx_idx     <= '0;
    end else begin
      if (fire) begin
        if (tx_idx == n_en - CW'(1)) begin
          tx_idx <= '0;
          if (tx2_pend) begin
            tx_word  <= tx2_word;
            tx2_pend <= 1'b0;
          end else begin
            tx_busy <= 1'b0;
          end
        end else begin
          tx_idx  <= tx_idx + CW'(1);
          tx_word <= tx_word >> GW;
        end
      end

      if (accept) begin
        if (!rle_en) begin
          if (n_en != '0) begin
            tx_word <= data_w;
            tx_busy <= 1'b1;
          end
        end else begin
          if (same) begin
            run_cnt <= run_cnt + DW'(1);
          end else begin
            if (have_run && n_en != '0) begin
              tx_word  <= run_val;
              tx2_word <= cnt_word;
              tx2_pend <= (run_cnt != '0);
              tx_busy  <= 1'b1;
            end
            run_val  <= data_w;
            run_cnt  <= '0;
            have_run <= 1'b1;
          end
          flush_pend <= s_last;
        end
      end else if (flush_pend && !tx_busy) begin
        if (n_en != '0) begin
          tx_word  <= run_val;
          tx2_word <= cnt_word;
          tx2_pend <= (run_cnt != '0);
          tx_busy  <= 1'b1;
        end
        have_run   <= 1'b0;
        flush_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rle_byte_packer_chk.sv
module rle_byte_packer_chk #(
  parameter int GROUPS = 4,
  parameter int GW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GROUPS-1:0] grp_off,
  input logic              rle_en,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [GW-1:0]     m_data
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!m_valid && s_ready)); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready); // R11
  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_off == '1 && !m_valid) |=> !m_valid); // R10
  AST_PLAIN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !rle_en && grp_off != '1) |=> m_valid); // R4
endmodule

bind rle_byte_packer rle_byte_packer_chk #(.GROUPS(GROUPS), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_off(grp_off), .rle_en(rle_en),
  .s_valid(s_valid), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data)
);

// File: tb/rle_byte_packer_bench.sv
`timescale 1ns/1ps
module rle_byte_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  grp_off = 4'h0;
  logic        rle_en = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        s_last = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data;

  int   checks = 0;
  int   fails  = 0;
  int   busy_err = 0;
  bit   stall_mode = 0;
  bit   done = 0;
  string cur_tag = "R1";
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  rle_byte_packer u_rle_byte_packer (
    .clk(clk), .rst_n(rst_n), .grp_off(grp_off), .rle_en(rle_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  initial forever begin
    @(posedge clk); #1;
    m_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (m_valid && s_ready) busy_err++;
      if (m_valid && m_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected byte %02h, expected none", cur_tag, m_data);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (m_data !== e) begin
            fails++;
            $display("FAIL %s: byte %02h, expected %02h", cur_tag, m_data, e);
          end
        end
      end
    end
  end

  function automatic int n_on(input logic [3:0] off);
    int n = 0;
    for (int g = 0; g < 4; g++) if (!off[g]) n++;
    return n;
  endfunction

  function automatic logic [31:0] squeeze(input logic [31:0] s, input logic [3:0] off, input bit rle);
    logic [31:0] w = '0;
    int k = 0;
    for (int g = 0; g < 4; g++)
      if (!off[g]) begin
        w[k*8 +: 8] = s[g*8 +: 8];
        k++;
      end
    if (rle && k > 0) w[k*8-1] = 1'b0;
    return w;
  endfunction

  task automatic push_word(input logic [31:0] w, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(w[k*8 +: 8]);
  endtask

  task automatic build_expect(input logic [31:0] smp[$], input logic [3:0] off, input bit rle);
    int n = n_on(off);
    longint cap = (n == 0) ? 0 : ((longint'(1) << (8*n-1)) - 1);
    int i = 0;
    if (n == 0) return;
    while (i < smp.size()) begin
      logic [31:0] v = squeeze(smp[i], off, rle);
      int run = 1;
      if (rle)
        while (i + run < smp.size() && squeeze(smp[i+run], off, rle) == v && longint'(run - 1) < cap)
          run++;
      push_word(v, n);
      if (run > 1) push_word((32'(1) << (8*n-1)) | 32'(run - 1), n);
      i += run;
    end
  endtask

  task automatic run_stream(input string tag, input logic [3:0] off, input bit rle,
                            input bit stall, input logic [31:0] smp[$]);
    int waitc = 0;
    @(posedge clk); #1;
    cur_tag = tag;
    grp_off = off;
    rle_en = rle;
    stall_mode = stall;
    busy_err = 0;
    build_expect(smp, off, rle);
    for (int i = 0; i < smp.size(); i++) begin
      s_valid = 1'b1;
      s_data = smp[i];
      s_last = (i == smp.size() - 1);
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1;
    end
    s_valid = 1'b0;
    s_last = 1'b0;
    while ((exp_q.size() != 0 || m_valid) && waitc < 3000) begin
      @(posedge clk);
      waitc++;
    end
    repeat (6) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d bytes missing, expected 0", tag, exp_q.size());
      exp_q.delete();
    end
    checks++;
    if (busy_err != 0) begin
      fails++;
      $display("FAIL R11 (%s): s_ready high while sending %0d times, expected 0", tag, busy_err);
    end
    stall_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] q[$];
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: m_valid=%b s_ready=%b, expected 0 1", m_valid, s_ready);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;

    q = '{32'h8877_6655, 32'h0403_0201, 32'hFFEE_DDCC};
    run_stream("R3 R4 plain all groups", 4'h0, 0, 0, q);

    q = '{32'hA1B2_C3D4, 32'h1122_3344, 32'h8899_AABB};
    run_stream("R2 plain groups 1,3", 4'b0101, 0, 0, q);

    q = '{32'h8000_1234, 32'h0000_1234, 32'h8000_1234, 32'h5555_AAAA,
          32'hC0DE_0001, 32'hC0DE_0001};
    run_stream("R5 R6 R8 rle runs", 4'h0, 1, 0, q);

    q = '{32'h0000_0001, 32'h0000_0002, 32'h0000_0003};
    run_stream("R6 rle singles", 4'h0, 1, 0, q);

    q = {};
    for (int i = 0; i < 129; i++) q.push_back(32'h0000_00C5);
    run_stream("R7 rle saturation", 4'b1110, 1, 0, q);

    q = '{32'hFF80_7F01, 32'h0080_7F01, 32'h1234_5678, 32'h1234_5678};
    run_stream("R2 R5 rle sparse mask", 4'b1011, 1, 0, q);

    q = {};
    for (int i = 0; i < 20; i++) q.push_back(32'h0102_0304 * (i + 1));
    run_stream("R9 plain stalls", 4'h0, 0, 1, q);

    q = {};
    for (int i = 0; i < 24; i++) q.push_back((i % 5 < 3) ? 32'h0000_7777 : 32'h0000_1111 + i);
    run_stream("R9 rle stalls", 4'b1100, 1, 1, q);

    q = '{32'h1111_1111, 32'h2222_2222, 32'h2222_2222};
    run_stream("R10 all off plain", 4'hF, 0, 0, q);
    run_stream("R10 all off rle", 4'hF, 1, 0, q);

    q = '{32'h0000_0042};
    run_stream("R8 single last", 4'b1110, 1, 0, q);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule